// File: doc/BRIEF.md
# Four-Decade BCD Up/Down Counter

This block keeps a four-digit decimal count in BCD and moves it by one on each rising edge of an asynchronous count input. The count input passes through a two-flop synchronizer and an edge detector in the system clock domain. The up/down input sets the direction. When the count wraps past the ends of the decimal range, the block raises a carry/borrow pulse one system clock wide. This pulse lets counters be cascaded.

Next to the counter sit two more four-digit values. A compare register feeds an active-low equal flag. A set of display latches copies the counter whenever the store input is held low. Both the counter and the register can be preset one digit at a time from a shared BCD nibble, using per-digit load strobes. A functional clear input sets the counter to zero. When that clear is taken while the count is 6000 or higher, it also produces a carry pulse.

Top module: `bcd_updown_counter`

## Requirements
- R1: A rising edge on `cnt_in` adds one to the count when `up_dn` is 1 and subtracts one when it is 0. Each digit stays in the range 0 to 9. The new value appears on `count_val` after the third `clk` edge following the rise of `cnt_in`. Digit k sits in bits [4k+3:4k], and digit 0 is the least significant.
- R2: `carry` is high for exactly one cycle. It is raised in the cycle the count changes from 9999 to 0000 while counting up, or from 0000 to 9999 while counting down, and in no other counting step.
- R3: `eq_n` is 0 exactly while `count_val` equals `reg_val`, and 1 otherwise.
- R4: `zero_n` is 0 exactly while `count_val` is 0000, and 1 otherwise.
- R5: A `clk` edge with `clr_n` low sets the counter to 0000. If the most significant digit was 6 or more before that edge, `carry` is 1 in the following cycle. Otherwise `carry` stays 0.
- R6: A count edge that arrives while `clr_n` is low, or while any bit of `ld_cnt` is high, is discarded. It is not applied later.
- R7: A `clk` edge with `store_n` low copies the counter value from before that edge into `disp_val`. While `store_n` is high, `disp_val` holds its value.
- R8: A register digit whose `ld_reg` bit is high at an edge where `clr_n` is low is loaded with 0, not with `din`.
- R9: At a `clk` edge with `clr_n` high, each counter digit whose `ld_cnt` bit is high takes the value of `din`, and each register digit whose `ld_reg` bit is high takes the value of `din`. Digits whose bits are low keep their values.
- R10: Loading counter digits never raises `carry`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| cnt_in | input | 1 | Asynchronous count input; its rising edges move the count |
| up_dn | input | 1 | Direction: 1 counts up, 0 counts down |
| store_n | input | 1 | Active low; copies the counter into the display latches |
| clr_n | input | 1 | Active-low functional clear of the counter, synchronous to clk |
| ld_cnt | input | 4 | Per-digit load strobes for the counter |
| ld_reg | input | 4 | Per-digit load strobes for the compare register |
| din | input | 4 | BCD nibble used by digit loads |
| count_val | output | 16 | Current counter value, BCD |
| reg_val | output | 16 | Compare register value, BCD |
| disp_val | output | 16 | Latched display value, BCD |
| carry | output | 1 | One-cycle carry/borrow pulse |
| eq_n | output | 1 | Low while counter equals register |
| zero_n | output | 1 | Low while counter is zero |

## Verification
A counting step and a display capture can land on the same clock edge. The bench holds `store_n` low through a count pulse. At the edge where the count moves, it expects `disp_val` to show the value from before the step. It expects the new value one cycle later. A count edge can also fall inside a counter load or a clear, with the count sitting at a wrap point. The bench holds the load strobe or the clear across the whole pulse. It then expects the count to stay put and no carry to appear.

// File: rtl/bcd_cnt_pkg.sv
package bcd_cnt_pkg;
  localparam int DIG_W = 4;
  typedef logic [DIG_W-1:0] bcd_t;
  localparam bcd_t BCD_TOP = 4'd9;
  localparam bcd_t BCD_BOT = 4'd0;
endpackage

// File: rtl/bcd_edge_sync.sv
module bcd_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise
);
  logic [STAGES:0] sh_q;
  logic [STAGES:0] sh_nxt;

  always_comb begin
    sh_nxt = {sh_q[STAGES-1:0], async_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_nxt;
  end

  assign rise = sh_q[STAGES-1] & ~sh_q[STAGES];
endmodule

// File: rtl/bcd_decade.sv
module bcd_decade
  import bcd_cnt_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic load,
  input  bcd_t load_val,
  input  logic step,
  input  logic up,
  output bcd_t digit,
  output logic term
);
  bcd_t dig_q;
  bcd_t dig_nxt;
  logic dig_en;

  always_comb begin
    dig_en  = clr | load | step;
    dig_nxt = dig_q;
    if (clr)       dig_nxt = BCD_BOT;
    else if (load) dig_nxt = load_val;
    else if (step) begin
      if (up) dig_nxt = (dig_q >= BCD_TOP) ? BCD_BOT : dig_q + 4'd1;
      else    dig_nxt = (dig_q == BCD_BOT) ? BCD_TOP : dig_q - 4'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      dig_q <= BCD_BOT;
    else if (dig_en) dig_q <= dig_nxt;
  end

  assign digit = dig_q;
  assign term  = up ? (dig_q >= BCD_TOP) : (dig_q == BCD_BOT);
endmodule

// File: rtl/bcd_updown_counter.sv
module bcd_updown_counter
  import bcd_cnt_pkg::*;
#(
  parameter int   NDIG      = 4,
  parameter int   SYNC_STG  = 2,
  parameter bcd_t CLR_CARRY = 4'd6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cnt_in,
  input  logic              up_dn,
  input  logic              store_n,
  input  logic              clr_n,
  input  logic [NDIG-1:0]   ld_cnt,
  input  logic [NDIG-1:0]   ld_reg,
  input  logic [3:0]        din,
  output logic [4*NDIG-1:0] count_val,
  output logic [4*NDIG-1:0] reg_val,
  output logic [4*NDIG-1:0] disp_val,
  output logic              carry,
  output logic              eq_n,
  output logic              zero_n
);
  localparam int W = NDIG * DIG_W;
  localparam logic [W-1:0] ALL_NINE = {NDIG{BCD_TOP}};

  logic          rise;
  logic          clr;
  logic          ld_any;
  logic          step;
  logic [NDIG:0] en;
  logic [NDIG-1:0] term;
  logic [W-1:0]  cnt;
  logic [W-1:0]  reg_q;
  logic [W-1:0]  disp_q;
  logic [W-1:0]  disp_nxt;
  logic          carry_q;
  logic          carry_nxt;

  bcd_edge_sync #(.STAGES(SYNC_STG)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(cnt_in), .rise(rise)
  );

  always_comb begin
    clr    = ~clr_n;
    ld_any = |ld_cnt;
    step   = rise & ~clr & ~ld_any;
  end

  assign en[0] = step;

  for (genvar i = 0; i < NDIG; i++) begin : g_dig
    bcd_t reg_nxt;

    bcd_decade u_dec (
      .clk(clk), .rst_n(rst_n), .clr(clr), .load(ld_cnt[i]),
      .load_val(din), .step(en[i]), .up(up_dn),
      .digit(cnt[DIG_W*i +: DIG_W]), .term(term[i])
    );
    assign en[i+1] = en[i] & term[i];

    always_comb begin
      reg_nxt = clr ? BCD_BOT : din;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         reg_q[DIG_W*i +: DIG_W] <= BCD_BOT;
      else if (ld_reg[i]) reg_q[DIG_W*i +: DIG_W] <= reg_nxt;
    end

    assert_regclr_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(ld_reg[i]) && !$past(clr_n)) |-> (reg_q[DIG_W*i +: DIG_W] == BCD_BOT));

    assert_ldcnt_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(ld_cnt[i]) && $past(clr_n)) |-> (cnt[DIG_W*i +: DIG_W] == $past(din)));
  end

  always_comb begin
    carry_nxt = clr ? (cnt[W-1 -: DIG_W] >= CLR_CARRY) : en[NDIG];
    disp_nxt  = cnt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) carry_q <= 1'b0;
    else        carry_q <= carry_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        disp_q <= '0;
    else if (!store_n) disp_q <= disp_nxt;
  end

  assign count_val = cnt;
  assign reg_val   = reg_q;
  assign disp_val  = disp_q;
  assign carry     = carry_q;
  assign eq_n      = (cnt != reg_q);
  assign zero_n    = (cnt != '0);

  assert_carry_src_R2: assert property (@(posedge clk) disable iff (!rst_n)
    carry |-> (!$past(clr_n) ||
               ($past(cnt) == ALL_NINE && $past(up_dn)) ||
               ($past(cnt) == '0 && !$past(up_dn))));

  assert_clr_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(clr_n) |-> (cnt == '0));

  assert_clr_nocarry_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(clr_n) && ($past(cnt[W-1 -: DIG_W]) < CLR_CARRY)) |-> !carry);

  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(clr_n) && !$past(rise) && ($past(ld_cnt) == '0)) |-> $stable(cnt));

  assert_latch_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(store_n) |-> (disp_val == $past(cnt)));

  assert_latch_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(store_n) |-> $stable(disp_val));

  assert_load_nocarry_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(clr_n) && ($past(ld_cnt) != '0)) |-> !carry);
endmodule

// File: tb/test_bcd_updown_counter.sv
module test_bcd_updown_counter;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cnt_in, up_dn, store_n, clr_n;
  logic [3:0]  ld_cnt, ld_reg, din;
  logic [15:0] count_val, reg_val, disp_val;
  logic        carry, eq_n, zero_n;

  int total = 0;
  int bad = 0;
  bit done = 0;

  typedef struct { logic [15:0] v; logic c; } item_t;
  item_t q[$];
  logic [15:0] exp_cnt;
  logic [15:0] exp_reg;

  always #(PERIOD/2) clk = ~clk;

  bcd_updown_counter i_bcd_updown_counter (
    .clk(clk), .rst_n(rst_n), .cnt_in(cnt_in), .up_dn(up_dn),
    .store_n(store_n), .clr_n(clr_n), .ld_cnt(ld_cnt), .ld_reg(ld_reg),
    .din(din), .count_val(count_val), .reg_val(reg_val),
    .disp_val(disp_val), .carry(carry), .eq_n(eq_n), .zero_n(zero_n)
  );

  function automatic int b2i(logic [15:0] b);
    return b[15:12]*1000 + b[11:8]*100 + b[7:4]*10 + b[3:0];
  endfunction

  function automatic logic [15:0] i2b(int n);
    return {4'((n/1000)%10), 4'((n/100)%10), 4'((n/10)%10), 4'(n%10)};
  endfunction

  task automatic chk(bit ok, string tag, logic [15:0] act, logic [15:0] expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  task automatic push(logic [15:0] v, logic c);
    item_t it;
    it.v = v; it.c = c;
    q.push_back(it);
    exp_cnt = v;
  endtask

  // count pulse; new value visible at the third negedge
  task automatic pulse(bit dir, bit effective);
    if (effective) begin
      if (dir) push(i2b((b2i(exp_cnt) + 1) % 10000), (b2i(exp_cnt) == 9999));
      else     push(i2b((b2i(exp_cnt) + 9999) % 10000), (b2i(exp_cnt) == 0));
    end
    up_dn = dir; cnt_in = 1'b1;
    repeat (3) @(negedge clk);
    cnt_in = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic ld_c(int i, logic [3:0] v);
    logic [15:0] nv;
    nv = exp_cnt;
    nv[4*i +: 4] = v;
    if (nv != exp_cnt) push(nv, 1'b0);
    ld_cnt[i] = 1'b1; din = v;
    @(negedge clk);
    ld_cnt = '0;
  endtask

  task automatic ld_r(int i, logic [3:0] v);
    exp_reg[4*i +: 4] = v;
    ld_reg[i] = 1'b1; din = v;
    @(negedge clk);
    ld_reg = '0;
  endtask

  // scoreboard monitor
  initial begin
    logic [15:0] last;
    item_t it;
    last = '0;
    forever begin
      @(negedge clk);
      if (rst_n !== 1'b1) begin
        last = count_val;
      end else if (count_val !== last) begin
        if (q.size() == 0) begin
          chk(1'b0, "R1 unexpected count change", count_val, last);
        end else begin
          it = q.pop_front();
          chk(count_val === it.v, "R1 count value", count_val, it.v);
          chk(carry === it.c, "R2 carry with step", {15'd0, carry}, {15'd0, it.c});
        end
        last = count_val;
      end else if (carry !== 1'b0) begin
        chk(1'b0, "R10 carry without count change", {15'd0, carry}, 16'd0);
      end
    end
  end

  initial begin
    #(PERIOD * 50000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cnt_in = 1'b0; up_dn = 1'b1; store_n = 1'b1; clr_n = 1'b1;
    ld_cnt = '0; ld_reg = '0; din = '0;
    exp_cnt = '0; exp_reg = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state
    chk(count_val == 16'h0, "R1 reset count", count_val, 16'h0);
    chk(zero_n == 1'b0, "R4 zero flag at reset", {15'd0, zero_n}, 16'd0);
    chk(eq_n == 1'b0, "R3 equal flag at reset", {15'd0, eq_n}, 16'd0);
    chk(disp_val == 16'h0, "R7 display at reset", disp_val, 16'h0);

    // R1 up and down
    pulse(1'b1, 1'b1); pulse(1'b1, 1'b1); pulse(1'b1, 1'b1);
    chk(zero_n == 1'b1, "R4 zero flag high when nonzero", {15'd0, zero_n}, 16'd1);
    chk(eq_n == 1'b1, "R3 equal flag high when different", {15'd0, eq_n}, 16'd1);
    pulse(1'b0, 1'b1); pulse(1'b0, 1'b1);
    chk(count_val == 16'h0001, "R1 after down", count_val, 16'h0001);

    // R9 per-digit preset to 9998
    ld_c(3, 4'd9); ld_c(2, 4'd9); ld_c(1, 4'd9); ld_c(0, 4'd8);
    chk(count_val == 16'h9998, "R9 counter preset", count_val, 16'h9998);

    // R2 wrap up and borrow down
    pulse(1'b1, 1'b1); pulse(1'b1, 1'b1);
    chk(zero_n == 1'b0, "R4 zero after wrap", {15'd0, zero_n}, 16'd0);
    pulse(1'b0, 1'b1);
    chk(count_val == 16'h9999, "R2 borrow to 9999", count_val, 16'h9999);

    // R3 register compare
    ld_r(0, 4'd9); ld_r(1, 4'd9); ld_r(2, 4'd9); ld_r(3, 4'd9);
    chk(reg_val == exp_reg, "R9 register preset", reg_val, exp_reg);
    chk(eq_n == 1'b0, "R3 equal low on match", {15'd0, eq_n}, 16'd0);
    pulse(1'b0, 1'b1);
    chk(eq_n == 1'b1, "R3 equal high on mismatch", {15'd0, eq_n}, 16'd1);

    // R7 store and hold
    store_n = 1'b0; @(negedge clk); store_n = 1'b1;
    chk(disp_val == 16'h9998, "R7 store copies counter", disp_val, 16'h9998);
    pulse(1'b0, 1'b1);
    chk(disp_val == 16'h9998, "R7 display holds", disp_val, 16'h9998);

    // R7 store and count step on the same edge
    store_n = 1'b0;
    push(16'h9996, 1'b0);
    up_dn = 1'b0; cnt_in = 1'b1;
    repeat (3) @(negedge clk);
    chk(disp_val == 16'h9997, "R7 same-edge store takes old count", disp_val, 16'h9997);
    @(negedge clk);
    chk(disp_val == 16'h9996, "R7 next store takes new count", disp_val, 16'h9996);
    cnt_in = 1'b0; store_n = 1'b1;
    repeat (3) @(negedge clk);

    // R6 and R10: count edge during a counter load at 9999
    ld_c(0, 4'd9);
    ld_cnt[0] = 1'b1; din = 4'd9; up_dn = 1'b1; cnt_in = 1'b1;
    repeat (3) @(negedge clk);
    cnt_in = 1'b0;
    repeat (3) @(negedge clk);
    ld_cnt = '0;
    @(negedge clk);
    chk(count_val == 16'h9999, "R6 count ignored during load", count_val, 16'h9999);

    // R5 clear at or above 6000
    push(16'h0000, 1'b1);
    clr_n = 1'b0; @(negedge clk); clr_n = 1'b1;
    chk(count_val == 16'h0, "R5 clear to zero", count_val, 16'h0);

    // R6 count edge during clear
    clr_n = 1'b0;
    pulse(1'b0, 1'b0);
    clr_n = 1'b1; @(negedge clk);
    chk(count_val == 16'h0, "R6 count ignored during clear", count_val, 16'h0);

    // R5 clear below 6000 gives no carry
    ld_c(3, 4'd5); ld_c(2, 4'd9); ld_c(1, 4'd9); ld_c(0, 4'd9);
    push(16'h0000, 1'b0);
    clr_n = 1'b0; @(negedge clk); clr_n = 1'b1;
    chk(count_val == 16'h0, "R5 clear from 5999", count_val, 16'h0);

    // R8 register load during clear
    clr_n = 1'b0; ld_reg = 4'hF; din = 4'd7;
    @(negedge clk);
    clr_n = 1'b1; ld_reg = '0; exp_reg = '0;
    chk(reg_val == 16'h0, "R8 register zeroed under clear", reg_val, 16'h0);
    chk(eq_n == 1'b0, "R3 equal after both zero", {15'd0, eq_n}, 16'd0);
    ld_r(1, 4'd3);
    chk(reg_val == 16'h0030, "R9 single register digit", reg_val, 16'h0030);

    repeat (4) @(negedge clk);
    chk(q.size() == 0, "R1 all expected steps seen", 16'(q.size()), 16'd0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule